// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block controls a bank of general-purpose pins, 64 or 96 of them, sized in multiples of 32. Software reaches it through a plain 32-bit register port: one write strobe, a byte address, write data and combinational read data. The block drives a per-pin output value and a per-pin output enable toward the pads. Each pin also gets a 2-bit alternate-function select.

Pad inputs pass through a two-flop synchroniser. The synchronised level can be read back, and it feeds an edge detector. Rising and falling edges are captured separately, each under its own per-pin enable, into a sticky status word that software clears by writing ones. All status bits are combined onto one interrupt line.

The register space is laid out type-major: all words of one feature sit next to each other, one word per 32 pins. Output values change only through the separate set and clear registers, never by writing the value directly.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset, the following are all zero: direction, output values, both edge enables, edge status, alternate-function fields and the interrupt line. Reading the direction registers then returns 0.
- R2: Register word addresses are type-major, with NW = NPINS/32. Group g word s sits at byte g*NW*4 + s*4, where s is pin/32. The pin's bit within the word is pin%32. The group order is: level 0, direction 1, set 2, clear 3, rising-enable 4, falling-enable 5, edge-status 6, alternate-function 7.
- R3: The level group reads the pad inputs after a two-flop synchroniser. A pad change made before clock edge A is still invisible after edge A and becomes readable after the following edge.
- R4: A direction bit of 1 makes the pin an output and 0 makes it an input. `pad_oe` follows the direction bits one cycle after the write.
- R5: Writing a 1 to a bit of the set group drives that pin's `pad_out` high on the next cycle. Zero bits leave the pin unchanged.
- R6: Writing a 1 to a bit of the clear group drives that pin's `pad_out` low on the next cycle. Zero bits leave the pin unchanged.
- R7: A 0-to-1 change of a synchronised input with its rising-enable bit set latches the pin's edge-status bit. So does a 1-to-0 change with its falling-enable bit set. An edge whose enable is clear is not captured.
- R8: Edge-status bits are sticky. Writing a 1 to a bit clears it, and writing a 0 leaves it unchanged.
- R9: If an enabled edge arrives in the same cycle as a write that clears its status bit, the bit stays set.
- R10: `irq` is high exactly when at least one edge-status bit is set.
- R11: The alternate-function group holds 2 bits per pin and 16 pins per word. Pin p sits in word p/16 at bits (p%16)*2+1:(p%16)*2, so the group spans 2*NW words. The field drives `alt_sel[2p+1:2p]`, and 0 means plain GPIO.
- R12: The set and clear groups read as 0. Word addresses past the end of the alternate-function group read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pad_in | input | NPINS | Asynchronous pad input levels |
| pad_out | output | NPINS | Pad output values |
| pad_oe | output | NPINS | Pad output enables (1 = drive) |
| alt_sel | output | 2*NPINS | Per-pin 2-bit alternate-function select |
| irq | output | 1 | OR of all edge-status bits |

## Verification
Some rules hold on every cycle, and the embedded assertions check those. An enabled edge is never dropped from status, even when it coincides with a clear. Status bits fall only where a clear write named them. The interrupt rises only after an edge hit. Outputs hold when nothing is written, and set and clear act on exactly the written lanes. Other behaviour needs the bench's directed scenarios plus a lockstep behavioural model: the two-cycle visibility delay of the level readback, the way the address map folds the groups and the double-width alternate-function group, and that out-of-range writes leave every other register untouched.

// File: rtl/pbc_pkg.sv
package pbc_pkg;

    localparam int WORD_BITS = 32;
    localparam int NUM_GROUPS = 8;

    typedef enum logic [2:0] {
        GRP_LEVEL = 3'd0,
        GRP_DIR   = 3'd1,
        GRP_SET   = 3'd2,
        GRP_CLR   = 3'd3,
        GRP_RISE  = 3'd4,
        GRP_FALL  = 3'd5,
        GRP_STAT  = 3'd6,
        GRP_ALT   = 3'd7
    } grp_e;

endpackage

// File: rtl/pbc_sync.sv
module pbc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = din;
        sync_d.stable = sync_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q.stable;

endmodule

// File: rtl/pbc_edge_cap.sv
module pbc_edge_cap #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] status,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] stat;
    } cap_t;

    cap_t         cap_d, cap_q;
    logic [W-1:0] hits;

    always_comb begin
        hits       = (rise_en & lvl & ~cap_q.prev) | (fall_en & ~lvl & cap_q.prev);
        cap_d      = cap_q;
        cap_d.prev = lvl;
        // a new edge outranks a simultaneous clear
        cap_d.stat = hits | (cap_q.stat & ~clr_mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign status = cap_q.stat;
    assign irq    = |cap_q.stat;

    p_edge_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hits) & ~status) == '0));

    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(status) & ~status & ~$past(clr_mask)) == '0));

    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(|hits));

endmodule

// File: rtl/pbc_addr_dec.sv
module pbc_addr_dec
    import pbc_pkg::*;
#(
    parameter int NW     = 3,
    parameter int ADDR_W = 8,
    localparam int SUB_W = $clog2(2 * NW)
) (
    input  logic [ADDR_W-3:0] word_idx,
    output grp_e              grp,
    output logic [SUB_W-1:0]  sub,
    output logic              hit
);
    localparam int ALT_BASE = (NUM_GROUPS - 1) * NW;
    localparam int ALT_END  = ALT_BASE + 2 * NW;

    int idx;

    always_comb begin
        idx = int'(word_idx);
        grp = GRP_LEVEL;
        sub = '0;
        hit = 1'b0;
        if (idx < ALT_BASE) begin
            grp = grp_e'(3'(idx / NW));
            sub = SUB_W'(idx % NW);
            hit = 1'b1;
        end else if (idx < ALT_END) begin
            grp = GRP_ALT;
            sub = SUB_W'(idx - ALT_BASE);
            hit = 1'b1;
        end
    end

endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
    import pbc_pkg::*;
#(
    parameter int NPINS  = 96,
    parameter int ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    input  logic [NPINS-1:0]     pad_in,
    output logic [NPINS-1:0]     pad_out,
    output logic [NPINS-1:0]     pad_oe,
    output logic [2*NPINS-1:0]   alt_sel,
    output logic                 irq
);
    localparam int NW    = NPINS / WORD_BITS;
    localparam int SUB_W = $clog2(2 * NW);

    typedef struct packed {
        logic [NPINS-1:0]   dir;
        logic [NPINS-1:0]   outv;
        logic [NPINS-1:0]   ren;
        logic [NPINS-1:0]   fen;
        logic [2*NPINS-1:0] alt;
    } regs_t;

    regs_t            regs_d, regs_q;
    grp_e             grp;
    logic [SUB_W-1:0] sub;
    logic             hit;
    logic [NPINS-1:0] lvl_sync;
    logic [NPINS-1:0] clr_mask;
    logic [NPINS-1:0] status;
    logic [NPINS-1:0] wr_lane;
    logic             unused_addr_lo;
    int               lane;

    assign unused_addr_lo = ^bus_addr[1:0];
    assign lane           = int'(sub) * WORD_BITS;

    pbc_addr_dec #(.NW(NW), .ADDR_W(ADDR_W)) dec_i (
        .word_idx (bus_addr[ADDR_W-1:2]),
        .grp      (grp),
        .sub      (sub),
        .hit      (hit)
    );

    pbc_sync #(.W(NPINS)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (lvl_sync)
    );

    pbc_edge_cap #(.W(NPINS)) cap_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl_sync),
        .rise_en (regs_q.ren),
        .fall_en (regs_q.fen),
        .clr_mask(clr_mask),
        .status  (status),
        .irq     (irq)
    );

    // write side
    always_comb begin
        regs_d   = regs_q;
        clr_mask = '0;
        wr_lane  = '0;
        if (int'(sub) < NW) wr_lane[lane +: WORD_BITS] = bus_wdata;
        if (bus_wr && hit) begin
            unique case (grp)
                GRP_DIR:  regs_d.dir[lane +: WORD_BITS]  = bus_wdata;
                GRP_SET:  regs_d.outv[lane +: WORD_BITS] = regs_q.outv[lane +: WORD_BITS] | bus_wdata;
                GRP_CLR:  regs_d.outv[lane +: WORD_BITS] = regs_q.outv[lane +: WORD_BITS] & ~bus_wdata;
                GRP_RISE: regs_d.ren[lane +: WORD_BITS]  = bus_wdata;
                GRP_FALL: regs_d.fen[lane +: WORD_BITS]  = bus_wdata;
                GRP_STAT: clr_mask[lane +: WORD_BITS]    = bus_wdata;
                GRP_ALT:  regs_d.alt[lane +: WORD_BITS]  = bus_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // read side
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            unique case (grp)
                GRP_LEVEL: bus_rdata = lvl_sync[lane +: WORD_BITS];
                GRP_DIR:   bus_rdata = regs_q.dir[lane +: WORD_BITS];
                GRP_RISE:  bus_rdata = regs_q.ren[lane +: WORD_BITS];
                GRP_FALL:  bus_rdata = regs_q.fen[lane +: WORD_BITS];
                GRP_STAT:  bus_rdata = status[lane +: WORD_BITS];
                GRP_ALT:   bus_rdata = regs_q.alt[lane +: WORD_BITS];
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign pad_out = regs_q.outv;
    assign pad_oe  = regs_q.dir;
    assign alt_sel = regs_q.alt;

    p_out_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(pad_out));

    p_set_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit && grp == GRP_SET) |=> ((pad_out & $past(wr_lane)) == $past(wr_lane)));

    p_clr_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit && grp == GRP_CLR) |=> ((pad_out & $past(wr_lane)) == '0));

    p_oob_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (bus_rdata == '0));

    p_wo_read_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && (grp == GRP_SET || grp == GRP_CLR)) |-> (bus_rdata == '0));

endmodule

// File: tb/pin_bank_ctrl_tb_top.sv
`timescale 1ns/1ps
module pin_bank_ctrl_tb_top;
    localparam int NPINS  = 96;
    localparam int ADDR_W = 8;
    localparam int NW     = NPINS / 32;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bus_wr = 1'b0;
    logic [ADDR_W-1:0]   bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic [31:0]         bus_rdata;
    logic [NPINS-1:0]    pad_in = '0;
    logic [NPINS-1:0]    pad_out;
    logic [NPINS-1:0]    pad_oe;
    logic [2*NPINS-1:0]  alt_sel;
    logic                irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    pin_bank_ctrl #(.NPINS(NPINS), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .alt_sel(alt_sel), .irq(irq)
    );

    // behavioural reference model
    logic [NPINS-1:0] m_s1, m_s2, m_prev, m_dir, m_out, m_ren, m_fen, m_st;
    logic [1:0]       m_af [NPINS];
    int               mw;
    bit               mh, mc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_dir <= '0;
            m_out <= '0; m_ren <= '0; m_fen <= '0; m_st <= '0;
            for (int p = 0; p < NPINS; p++) m_af[p] <= 2'b00;
        end else begin
            mw = int'(bus_addr) >> 2;
            m_s1 <= pad_in; m_s2 <= m_s1; m_prev <= m_s2;
            for (int p = 0; p < NPINS; p++) begin
                mh = (m_ren[p] && m_s2[p] && !m_prev[p]) || (m_fen[p] && !m_s2[p] && m_prev[p]);
                mc = bus_wr && (mw == 6*NW + p/32) && bus_wdata[p%32];
                m_st[p] <= mh || (m_st[p] && !mc);
                if (bus_wr) begin
                    if (mw == 1*NW + p/32) m_dir[p] <= bus_wdata[p%32];
                    if (mw == 2*NW + p/32 && bus_wdata[p%32]) m_out[p] <= 1'b1;
                    if (mw == 3*NW + p/32 && bus_wdata[p%32]) m_out[p] <= 1'b0;
                    if (mw == 4*NW + p/32) m_ren[p] <= bus_wdata[p%32];
                    if (mw == 5*NW + p/32) m_fen[p] <= bus_wdata[p%32];
                    if (mw == 7*NW + p/16) m_af[p] <= bus_wdata[(p%16)*2 +: 2];
                end
            end
        end
    end

    function automatic logic [31:0] model_read(input int addr);
        logic [31:0] r;
        int w;
        w = addr >> 2;
        r = '0;
        for (int b = 0; b < 32; b++) begin
            if (w < NW)                       r[b] = m_s2[w*32 + b];
            else if (w < 2*NW)                r[b] = m_dir[(w-NW)*32 + b];
            else if (w >= 4*NW && w < 5*NW)   r[b] = m_ren[(w-4*NW)*32 + b];
            else if (w >= 5*NW && w < 6*NW)   r[b] = m_fen[(w-5*NW)*32 + b];
            else if (w >= 6*NW && w < 7*NW)   r[b] = m_st[(w-6*NW)*32 + b];
            else if (w >= 7*NW && w < 9*NW)   r[b] = m_af[(w-7*NW)*16 + b/2][b%2];
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [191:0] act, input logic [191:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // lockstep comparison on every clock, away from the active edge
    logic [2*NPINS-1:0] m_alt_flat;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int p = 0; p < NPINS; p++) m_alt_flat[2*p +: 2] = m_af[p];
            chk(pad_out === m_out, "R5,R6 lockstep pad_out", pad_out, m_out);
            chk(pad_oe === m_dir, "R4 lockstep pad_oe", pad_oe, m_dir);
            chk(irq === (|m_st), "R10 lockstep irq", irq, |m_st);
            chk(alt_sel === m_alt_flat, "R11 lockstep alt_sel", alt_sel, m_alt_flat);
        end
    end

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(addr); bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int addr, input logic [31:0] exp, input string tag);
        bus_addr = ADDR_W'(addr);
        #1;
        chk(bus_rdata === exp, tag, bus_rdata, exp);
        chk(bus_rdata === model_read(addr), {tag, " vs model"}, bus_rdata, model_read(addr));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pad_out == '0 && pad_oe == '0, "R1 reset outputs", {pad_out, pad_oe}, '0);
        chk(alt_sel == '0 && irq == 1'b0, "R1 reset alt/irq", {alt_sel, irq}, '0);
        rd(12, 32'h0, "R1 dir word0 after reset");
        rd(20, 32'h0, "R1 dir word2 after reset");

        // R2 R4 direction, word 1
        wr(16, 32'hA5A5_0F0F);
        rd(16, 32'hA5A5_0F0F, "R2 dir word1 readback");
        rd(12, 32'h0, "R2 dir word0 untouched");
        chk(pad_oe[63:32] == 32'hA5A5_0F0F, "R4 pad_oe lane1", pad_oe[63:32], 32'hA5A5_0F0F);

        // R5 R6 set/clear on word 2
        wr(32, 32'h0000_00FF);
        chk(pad_out[95:64] == 32'h0000_00FF, "R5 set lane2", pad_out[95:64], 32'hFF);
        wr(32, 32'h0000_0100);
        chk(pad_out[95:64] == 32'h0000_01FF, "R5 zero bits keep", pad_out[95:64], 32'h1FF);
        wr(44, 32'h0000_000F);
        chk(pad_out[95:64] == 32'h0000_01F0, "R6 clear lane2", pad_out[95:64], 32'h1F0);
        chk(pad_out[63:0] == '0, "R6 other lanes untouched", pad_out[63:0], '0);
        rd(32, 32'h0, "R12 set group reads 0");
        rd(44, 32'h0, "R12 clear group reads 0");

        // R3 two-flop level visibility
        @(negedge clk);
        pad_in[31:0] = 32'h1234_5678;
        @(negedge clk);
        rd(0, 32'h0, "R3 level hidden after one edge");
        @(negedge clk);
        rd(0, 32'h1234_5678, "R3 level visible after two edges");

        // R7 edge capture
        wr(48, 32'h0000_0001);
        wr(60, 32'h0000_0002);
        @(negedge clk); pad_in[0] = 1'b1;
        idle(4);
        rd(72, 32'h1, "R7 rising edge captured");
        chk(irq == 1'b1, "R10 irq with status set", irq, 1'b1);
        pad_in[1] = 1'b1; pad_in[2] = 1'b1;
        idle(4);
        rd(72, 32'h1, "R7 unenabled rises ignored");
        pad_in[1] = 1'b0;
        idle(4);
        rd(72, 32'h3, "R7 falling edge captured");

        // R8 write-one-to-clear
        wr(72, 32'h0000_0001);
        rd(72, 32'h2, "R8 clear bit0");
        wr(72, 32'h0000_0000);
        rd(72, 32'h2, "R8 zero write keeps");
        wr(72, 32'h0000_0002);
        rd(72, 32'h0, "R8 clear bit1");
        @(negedge clk);
        chk(irq == 1'b0, "R10 irq low when clear", irq, 1'b0);

        // R9 edge in the same cycle as its clear
        pad_in[0] = 1'b0;
        idle(4);
        pad_in[0] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = ADDR_W'(72); bus_wdata = 32'h1;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(72, 32'h1, "R9 edge beats clear");

        // R11 alternate function
        wr(88, 32'h0000_000C);
        chk(alt_sel[35:34] == 2'b11, "R11 pin17 field", alt_sel[35:34], 2'b11);
        chk(alt_sel[33:32] == 2'b00, "R11 pin16 field", alt_sel[33:32], 2'b00);
        rd(88, 32'h0000_000C, "R11 alt word1 readback");
        wr(104, 32'hC000_0000);
        chk(alt_sel[191:190] == 2'b11, "R11 pin95 field", alt_sel[191:190], 2'b11);
        rd(104, 32'hC000_0000, "R11 last alt word readback");

        // R12 out of range
        wr(108, 32'hFFFF_FFFF);
        rd(108, 32'h0, "R12 oob reads 0");
        rd(252, 32'h0, "R12 far oob reads 0");
        chk(pad_out[95:64] == 32'h0000_01F0, "R12 oob write ignored", pad_out[95:64], 32'h1F0);
        rd(16, 32'hA5A5_0F0F, "R12 dir intact after oob write");

        idle(2);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule